// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the target side of a two-wire (I2C) serial memory holding 2048 bytes. It watches the clock and data lines, detects start, repeated start and stop conditions, checks the device code in the first byte of a frame, and answers on the data line through an open-drain pull-down enable. Frames with the direction bit at 1 stream bytes out of an internal synchronous array. Frames with the direction bit at 0 only load the address pointer. A separate preload port fills the array before or between bus transfers.

There are three ways to read. A current-address read returns the byte under the shared pointer. A random read is a short write frame that sets the pointer, then a repeated start and a read frame. In a sequential read, each master acknowledge asks for the byte at the next address, and the pointer wraps from the top of the array to 0. The pointer always rests one past the last byte fully sent.

The controller is a state machine with these states: `ST_IDLE`, `ST_DEV_RX` (shifting in the device byte), `ST_DEV_ACK`, `ST_ADR_RX` (shifting in the word address), `ST_ADR_ACK`, `ST_TX` (shifting a data byte out) and `ST_MST_ACK` (waiting for the master's acknowledge bit). The transitions are as follows:
- A stop moves any state to `ST_IDLE`.
- A start moves any state to `ST_DEV_RX`.
- From `ST_DEV_RX`, after eight bits, the machine goes to `ST_DEV_ACK` if the code matches and to `ST_IDLE` if it does not.
- From `ST_DEV_ACK`, a read frame goes to `ST_TX` and a write frame goes to `ST_ADR_RX`.
- `ST_ADR_RX` goes to `ST_ADR_ACK` after eight bits.
- `ST_ADR_ACK` goes to `ST_IDLE`.
- `ST_TX` goes to `ST_MST_ACK` after eight bits.
- From `ST_MST_ACK`, an acknowledge goes back to `ST_TX` and a no-acknowledge goes to `ST_IDLE`.

Top module: `sr_serial_rom_slave`

## Requirements
- R1: After reset the slave does not pull SDA (`sda_oe` = 0), and the address pointer is 0, so a first current-address read returns the byte at address 0.
- R2: The device byte is laid out as follows: bits [7:4] are the device code 4'b1010, bits [3:1] are the block bits, and bit 0 is the direction (1 = read), all sent MSB first. On a code match the slave pulls SDA low during the ninth clock. On a mismatch it leaves SDA released for the rest of the frame, and the pointer is unchanged.
- R3: In a write frame the slave acknowledges the next byte and loads the pointer with {block bits, that byte}. Any further byte in that frame gets no acknowledge and changes neither the memory nor the pointer.
- R4: In a read frame the slave acknowledges, then sends the byte at the pointer MSB first. Once the eighth bit has gone out, the pointer advances by 1.
- R5: The block bits of a read-frame device byte are ignored. A current-address read returns the byte under the pointer whatever those bits hold.
- R6: A master acknowledge after a data byte makes the slave send the byte at the next address. Address 2047 is followed by address 0.
- R7: A master no-acknowledge makes the slave release SDA and go idle. The pointer stays one past the last byte sent.
- R8: A start or stop condition seen anywhere, including mid-byte, discards the partial byte. After a start, the next eight clocks are taken as a new device byte. A stop in the middle of an address byte leaves the pointer unchanged.
- R9: The slave begins pulling SDA low only while SCL is low.
- R10: A write on the preload port (`pl_we`, `pl_addr`, `pl_data`) stores the byte, and a later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 11 | Preload byte address |
| pl_data | input | 8 | Preload byte value |

## Verification
The hardest case to reach from the pins is a wrap of a sequential read across the top of the array with the pointer state intact. To get there, the bench has to set up a dummy write to address 2046 and then acknowledge several bytes in a row. A second hard case is a start or stop arriving in the middle of a device or address byte. The bench reaches it with a partial-byte bit task followed by an immediate start or stop, and then proves the recovery by running a full read. A seeded random mix of random reads and current-address reads of random length follows these directed cases. That mix keeps the bench's pointer model in step with the design across many frame boundaries.

// File: rtl/sr_pkg.sv
package sr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV_RX,
        ST_DEV_ACK,
        ST_ADR_RX,
        ST_ADR_ACK,
        ST_TX,
        ST_MST_ACK
    } sr_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/sr_line_sync.sv
module sr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_lvl   = scl_ff[STAGES-1];
    assign sda_lvl   = sda_ff[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/sr_mem_array.sv
module sr_mem_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end
endmodule

// File: rtl/sr_serial_rom_slave.sv
module sr_serial_rom_slave
    import sr_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              pl_we,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [7:0]        pl_data
);
    localparam int LO_W  = 8;
    localparam int BLK_W = ADDR_W - LO_W;
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    sr_state_e state_q, st_d;
    logic [3:0]        cnt_q;
    logic [7:0]        shreg_q, txsh_q, rdata;
    logic [ADDR_W-1:0] ptr_q;
    logic [BLK_W-1:0]  blk_q;
    logic              mack_q;

    sr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    sr_mem_array #(.AW(ADDR_W), .DW(8)) u_mem (
        .clk(clk), .we(pl_we), .waddr(pl_addr), .wdata(pl_data),
        .raddr(ptr_q), .rdata(rdata)
    );

    // next-state logic
    always_comb begin
        st_d = state_q;
        if (stop_det) begin
            st_d = ST_IDLE;
        end else if (start_det) begin
            st_d = ST_DEV_RX;
        end else begin
            unique case (state_q)
                ST_IDLE:    st_d = ST_IDLE;
                ST_DEV_RX:  if (scl_fall && cnt_q == 4'd8)
                                st_d = (shreg_q[7:4] == DEV_CODE) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: if (scl_fall) st_d = shreg_q[0] ? ST_TX : ST_ADR_RX;
                ST_ADR_RX:  if (scl_fall && cnt_q == 4'd8) st_d = ST_ADR_ACK;
                ST_ADR_ACK: if (scl_fall) st_d = ST_IDLE;
                ST_TX:      if (scl_fall && cnt_q == 4'd7) st_d = ST_MST_ACK;
                ST_MST_ACK: if (scl_fall) st_d = mack_q ? ST_TX : ST_IDLE;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= st_d;
    end

    // datapath: bit counter, shifters, pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            txsh_q  <= '0;
            ptr_q   <= '0;
            blk_q   <= '0;
            mack_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q <= '0;
        end else begin
            case (state_q)
                ST_DEV_RX, ST_ADR_RX: begin
                    if (scl_rise && cnt_q != 4'd8) begin
                        shreg_q <= {shreg_q[6:0], sda_lvl};
                        cnt_q   <= cnt_q + 4'd1;
                    end else if (scl_fall && cnt_q == 4'd8) begin
                        cnt_q <= '0;
                        if (state_q == ST_DEV_RX) blk_q <= shreg_q[BLK_W:1];
                        else                      ptr_q <= {blk_q, shreg_q};
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (shreg_q[0]) txsh_q <= rdata;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == 4'd7) begin
                            ptr_q <= ptr_q + PTR_ONE;
                        end else begin
                            txsh_q <= {txsh_q[6:0], 1'b0};
                            cnt_q  <= cnt_q + 4'd1;
                        end
                    end
                end
                ST_MST_ACK: begin
                    if (scl_rise) mack_q <= ~sda_lvl;
                    else if (scl_fall && mack_q) begin
                        txsh_q <= rdata;
                        cnt_q  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DEV_ACK, ST_ADR_ACK: sda_oe = 1'b1;
            ST_TX:                  sda_oe = ~txsh_q[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    // R9: the pull-down only begins while the clock line is low
    p_oe_rise_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    // R8: a stop always leads to idle, a start to a fresh device byte
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> state_q == ST_IDLE);
    p_start_fresh_r8: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state_q == ST_DEV_RX && cnt_q == 4'd0));

    // R2: acknowledging the device byte needs a matching code
    p_code_match_r2: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_DEV_ACK |-> shreg_q[7:4] == DEV_CODE);

    // R4: completing a byte moves the pointer by exactly one
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MST_ACK && $past(state_q) == ST_TX) |->
            ptr_q == $past(ptr_q) + PTR_ONE);
endmodule

// File: tb/sim_sr_serial_rom_slave.sv
module sim_sr_serial_rom_slave;
    localparam int AW = 11;
    localparam int DEPTH = 1 << AW;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic pl_we = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [7:0] pl_data = '0;
    wire sda_bus = ~(m_low | sda_oe);

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] mem_m [DEPTH];
    logic [AW-1:0] ptr_m = '0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    sr_serial_rom_slave u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
    );

    function automatic logic [7:0] dev_byte(input logic [2:0] blk, input logic rd);
        return {4'b1010, blk, rd};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [AW-1:0] a);
        return mem_m[a];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R9 monitor: a new pull-down must start while SCL is low
    always @(negedge clk) begin
        oe_prev <= sda_oe;
        if (!rst && sda_oe && !oe_prev) chk("R9 oe rise with scl high", int'(scl), 0);
    end

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; hq(); scl = 1'b1; hq(); m_low = 1'b1; hq(); scl = 1'b0; hq();
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; hq(); scl = 1'b1; hq(); m_low = 1'b0; hq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_low = 1'b0; hq(); scl = 1'b1; hq(); ack = sda_bus; hq(); scl = 1'b0; hq();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hq(); scl = 1'b1; hq(); b = {b[6:0], sda_bus}; hq(); scl = 1'b0;
        end
        hq(); m_low = mack; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq(); m_low = 1'b0;
    endtask

    task automatic read_run(input int len, input string req);
        logic [7:0] b;
        for (int k = 0; k < len; k++) begin
            recv_byte(k != len - 1, b);
            chk(req, b, exp_byte(ptr_m));
            ptr_m = ptr_m + 1'b1;
        end
    endtask

    task automatic cur_read(input logic [2:0] blk, input int len, input string req);
        logic ack;
        i2c_start();
        send_byte(dev_byte(blk, 1'b1), ack);
        chk({req, " read dev ack"}, ack, 0);
        read_run(len, req);
        i2c_stop();
    endtask

    task automatic rand_read(input logic [AW-1:0] a, input int len, input string req);
        logic ack;
        i2c_start();
        send_byte(dev_byte(a[10:8], 1'b0), ack);
        chk("R3 write dev ack", ack, 0);
        send_byte(a[7:0], ack);
        chk("R3 address ack", ack, 0);
        ptr_m = a;
        i2c_start();
        send_byte(dev_byte(3'($urandom), 1'b1), ack);
        chk("R4 read dev ack", ack, 0);
        read_run(len, req);
        i2c_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        void'($urandom(32'd4711));
        for (int a = 0; a < DEPTH; a++) mem_m[a] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk("R1 sda_oe in reset", sda_oe, 0);
        for (int a = 0; a < DEPTH; a++) begin
            pl_we = 1'b1; pl_addr = AW'(a); pl_data = mem_m[a];
            @(negedge clk);
        end
        pl_we = 1'b0;
        @(negedge clk); rst = 1'b0; hq();
        chk("R1 sda_oe after reset", sda_oe, 0);

        // R1: pointer starts at 0; R4: two bytes in a row
        cur_read(3'd0, 2, "R1 R4 first current read");

        // R10: preload a known value then fetch it
        pl_we = 1'b1; pl_addr = 11'h400; pl_data = 8'hC3; @(negedge clk); pl_we = 1'b0;
        mem_m[11'h400] = 8'hC3;
        rand_read(11'h400, 1, "R10 preloaded byte");
        chk("R10 value", exp_byte(11'h400), 8'hC3);

        // R3/R4: random read with block bits
        rand_read(11'h2A5, 1, "R3 random read");
        // R5: block bits in read byte ignored; R7: pointer one past after NACK
        cur_read(3'd7, 1, "R5 R7 current read, other block bits");

        // R2: wrong code gets no ack, bus ignored, pointer unchanged
        i2c_start();
        send_byte(8'b1011_0001, ack);
        chk("R2 mismatch ack", ack, 1);
        recv_byte(1'b0, b);
        chk("R2 line released", b, 8'hFF);
        i2c_stop();
        cur_read(3'd0, 1, "R2 pointer kept after mismatch");

        // R6: wrap from top of array
        rand_read(11'h7FE, 4, "R6 sequential wrap");
        chk("R6 pointer after wrap", ptr_m, 11'h002);

        // R3: extra byte in write frame not acked, not stored
        i2c_start();
        send_byte(dev_byte(3'd1, 1'b0), ack);
        send_byte(8'h10, ack);
        ptr_m = 11'h110;
        send_byte(~mem_m[11'h110], ack);
        chk("R3 data byte not acked", ack, 1);
        i2c_stop();
        cur_read(3'd0, 1, "R3 memory and pointer untouched");

        // R8: start mid device byte, then a full read
        i2c_start();
        send_bits(8'b1010_0000, 5);
        rand_read(11'h333, 2, "R8 recovery after mid-byte start");

        // R8: stop mid address byte leaves pointer
        i2c_start();
        send_byte(dev_byte(3'd5, 1'b0), ack);
        send_bits(8'h00, 3);
        m_low = 1'b1; hq(); scl = 1'b1; hq(); m_low = 1'b0; hq();
        cur_read(3'd0, 1, "R8 pointer kept after mid-address stop");

        // constrained random mix
        for (int it = 0; it < 25; it++) begin
            int len;
            len = 1 + int'($urandom_range(0, 4));
            if ($urandom_range(0, 1) == 1) rand_read(AW'($urandom), len, "R6 random sequential read");
            else cur_read(3'($urandom), len, "R4 random current read");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule